// File: doc/BRIEF.md
# IOMMU Control and Fault Register Bank

This block is the software-visible face of an address-translation walker. Software uses a simple 32-bit register bus to load the page-table base pointer, switch on out-of-bound checking, enable fault reporting and turn translation on. The bank drives the walker with a translation enable, the base pointer, the out-of-bound check enable and a single-cycle flush pulse.

In the other direction, the walker reports fault events, each with a cause code and a faulting virtual address. The bank ORs each cause into a sticky status word. It latches the address of the first fault that arrives after status was last cleared. It holds a level interrupt high while reporting is enabled and any status bit is set. Software clears status by writing zeros to it.

The expected bring-up order is: base pointer, configuration, exception enable, control enable, then a flush command, written as a 1 followed by a 0 on the flush bit. Writing 0 to the control register turns translation off, so accesses then pass through unchanged.

Top module: `iommu_regbank`

## Requirements
- R1: After synchronous reset, every output is 0 and every register offset reads 0; translation and exception reporting are both disabled.
- R2: Offset 0x38C holds a full 32-bit table base pointer. It is written whole, read back whole and driven on `table_base`.
- R3: At offset 0x1AC only bit 28 is stored. It drives `oob_check_en`, and a read of this offset returns only that bit.
- R4: At offset 0x388 bit 0 is the translation enable. It drives `xlat_en` and reads back in bit 0; writing 0 clears it.
- R5: A write to offset 0x380 sets the exception-report enable from bit 0. A read of 0x380 returns the captured fault address, not the enable.
- R6: Offset 0x384 reads the sticky status in bits 2:0. Each fault cause is ORed into it. A write keeps only the status bits where the written data has a 1, so writing 0 clears all of them. A fault in the same cycle as such a write is applied after the write.
- R7: A fault event with a nonzero cause latches its address only when status is zero after any same-cycle write. Later faults leave the address unchanged, and an event with cause 0 has no effect.
- R8: `irq` equals the exception-report enable ANDed with the OR of the status bits, both taken from registered state, so it follows a change one cycle later.
- R9: At offset 0x184 bit 4 is stored and readable. A write that moves it from 0 to 1 gives one `flush_pulse` cycle in the next cycle. Writing 1 while it is already 1 gives no pulse.
- R10: Reads from any offset other than the six above return 0, and writes to them change nothing.
- R11: Read data appears on `bus_rdata` in the cycle after the read request and is 0 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| fault_valid | input | 1 | Fault event from the walker |
| fault_cause | input | 3 | Cause bits of the fault event |
| fault_vaddr | input | 32 | Faulting virtual address |
| xlat_en | output | 1 | Translation enable to the walker |
| table_base | output | 32 | Page-table base pointer to the walker |
| oob_check_en | output | 1 | Out-of-bound check enable to the walker |
| flush_pulse | output | 1 | One-cycle translation-cache flush |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes each mapped register with all ones and with sparse values. This separates full-width storage from single-bit fields and shows whether the unused bits of a field are dropped. Fault events arrive in several forms: a single fault, back-to-back faults with different causes and addresses, an event with a zero cause, and a fault in the same cycle as a status clear. These tell first-fault capture apart from last-fault capture, and clear-wins ordering apart from fault-wins ordering. Flush writes of 1, 1, 0, 1 show whether pulses come from the rising edge of the bit or from the level. Accesses to an unmapped offset, and toggling the exception enable with status held set, isolate the decode and the interrupt gating.

// File: rtl/iommu_regbank_pkg.sv
package iommu_regbank_pkg;

    localparam int RB_ADDR_W  = 12;
    localparam int RB_DATA_W  = 32;
    localparam int RB_CAUSE_W = 3;

    // register slots, indexes into the decode vector
    localparam int SLOT_BASE  = 0;
    localparam int SLOT_CFG   = 1;
    localparam int SLOT_CTRL  = 2;
    localparam int SLOT_EXC   = 3;
    localparam int SLOT_STAT  = 4;
    localparam int SLOT_FLUSH = 5;
    localparam int NUM_SLOTS  = 6;

    // field positions that the walker-side software contract depends on
    localparam int OOB_BIT   = 28;
    localparam int EN_BIT    = 0;
    localparam int FLUSH_BIT = 4;

    function automatic logic [RB_ADDR_W-1:0] slot_offset(input int slot);
        logic [RB_ADDR_W-1:0] off;
        case (slot)
            SLOT_BASE:  off = 12'h38C;
            SLOT_CFG:   off = 12'h1AC;
            SLOT_CTRL:  off = 12'h388;
            SLOT_EXC:   off = 12'h380;
            SLOT_STAT:  off = 12'h384;
            SLOT_FLUSH: off = 12'h184;
            default:    off = '1;
        endcase
        return off;
    endfunction

    typedef struct packed {
        logic                  vld;
        logic [RB_CAUSE_W-1:0] cause;
        logic [RB_DATA_W-1:0]  vaddr;
    } fault_evt_t;

    typedef struct packed {
        logic [RB_DATA_W-1:0] base;
        logic                 oob;
        logic                 xlat;
        logic                 exc;
    } walker_cfg_t;

endpackage

// File: rtl/iommu_rb_decode.sv
module iommu_rb_decode
    import iommu_regbank_pkg::*;
#(
    parameter int ADDR_W = RB_ADDR_W,
    parameter int NUM    = NUM_SLOTS
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM-1:0]    wr_hit,
    output logic [NUM-1:0]    rd_hit
);
    logic [NUM-1:0] match;

    for (genvar i = 0; i < NUM; i++) begin : g_slot
        assign match[i] = (bus_addr == ADDR_W'(slot_offset(i)));
    end

    assign wr_hit = (bus_sel &&  bus_wr) ? match : '0;
    assign rd_hit = (bus_sel && !bus_wr) ? match : '0;
endmodule

// File: rtl/iommu_rb_fault.sv
module iommu_rb_fault
    import iommu_regbank_pkg::*;
#(
    parameter int DATA_W  = RB_DATA_W,
    parameter int CAUSE_W = RB_CAUSE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_wr,
    input  logic [CAUSE_W-1:0] clr_keep,
    input  logic               evt_vld,
    input  logic [CAUSE_W-1:0] evt_cause,
    input  logic [DATA_W-1:0]  evt_vaddr,
    input  logic               exc_en,
    output logic [CAUSE_W-1:0] status_q,
    output logic [DATA_W-1:0]  faddr_q,
    output logic               irq
);
    logic [CAUSE_W-1:0] kept;
    logic [CAUSE_W-1:0] status_d;
    logic               take;
    logic               capture;

    always_comb begin
        kept     = clr_wr ? (status_q & clr_keep) : status_q;
        take     = evt_vld && (evt_cause != '0);
        status_d = kept | (take ? evt_cause : '0);
        capture  = take && (kept == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            faddr_q  <= '0;
        end else begin
            status_q <= status_d;
            if (capture) faddr_q <= evt_vaddr;
        end
    end

    assign irq = exc_en && (status_q != '0);
endmodule

// File: rtl/iommu_rb_flush.sv
module iommu_rb_flush
    import iommu_regbank_pkg::*;
#(
    parameter int DATA_W = RB_DATA_W,
    parameter int BIT    = FLUSH_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_q,
    output logic              pulse_q
);
    logic rising;

    assign rising = wr_hit && wdata[BIT] && !cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= rising;
            if (wr_hit) cmd_q <= wdata[BIT];
        end
    end
endmodule

// File: rtl/iommu_regbank.sv
module iommu_regbank
    import iommu_regbank_pkg::*;
#(
    parameter int ADDR_W  = RB_ADDR_W,
    parameter int DATA_W  = RB_DATA_W,
    parameter int CAUSE_W = RB_CAUSE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               fault_valid,
    input  logic [CAUSE_W-1:0] fault_cause,
    input  logic [DATA_W-1:0]  fault_vaddr,
    output logic               xlat_en,
    output logic [DATA_W-1:0]  table_base,
    output logic               oob_check_en,
    output logic               flush_pulse,
    output logic               irq
);
    localparam int NUM = NUM_SLOTS;

    logic [NUM-1:0]     wr_hit;
    logic [NUM-1:0]     rd_hit;
    walker_cfg_t        cfg_q;
    fault_evt_t         evt;
    logic [CAUSE_W-1:0] status_q;
    logic [DATA_W-1:0]  faddr_q;
    logic               flush_cmd_q;
    logic [DATA_W-1:0]  rd_mux;

    iommu_rb_decode #(.ADDR_W(ADDR_W), .NUM(NUM)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (wr_hit[SLOT_BASE]) cfg_q.base <= bus_wdata;
            if (wr_hit[SLOT_CFG])  cfg_q.oob  <= bus_wdata[OOB_BIT];
            if (wr_hit[SLOT_CTRL]) cfg_q.xlat <= bus_wdata[EN_BIT];
            if (wr_hit[SLOT_EXC])  cfg_q.exc  <= bus_wdata[EN_BIT];
        end
    end

    assign evt.vld   = fault_valid;
    assign evt.cause = fault_cause;
    assign evt.vaddr = fault_vaddr;

    iommu_rb_fault #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_fault (
        .clk      (clk),
        .rst      (rst),
        .clr_wr   (wr_hit[SLOT_STAT]),
        .clr_keep (bus_wdata[CAUSE_W-1:0]),
        .evt_vld  (evt.vld),
        .evt_cause(evt.cause),
        .evt_vaddr(evt.vaddr),
        .exc_en   (cfg_q.exc),
        .status_q (status_q),
        .faddr_q  (faddr_q),
        .irq      (irq)
    );

    iommu_rb_flush #(.DATA_W(DATA_W), .BIT(FLUSH_BIT)) u_flush (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit[SLOT_FLUSH]),
        .wdata  (bus_wdata),
        .cmd_q  (flush_cmd_q),
        .pulse_q(flush_pulse)
    );

    always_comb begin
        rd_mux = '0;
        if (rd_hit[SLOT_BASE])  rd_mux = cfg_q.base;
        if (rd_hit[SLOT_CFG])   rd_mux[OOB_BIT] = cfg_q.oob;
        if (rd_hit[SLOT_CTRL])  rd_mux[EN_BIT] = cfg_q.xlat;
        if (rd_hit[SLOT_EXC])   rd_mux = faddr_q;
        if (rd_hit[SLOT_STAT])  rd_mux[CAUSE_W-1:0] = status_q;
        if (rd_hit[SLOT_FLUSH]) rd_mux[FLUSH_BIT] = flush_cmd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

    assign xlat_en      = cfg_q.xlat;
    assign table_base   = cfg_q.base;
    assign oob_check_en = cfg_q.oob;
endmodule

// File: rtl/iommu_rb_checker.sv
module iommu_rb_checker
    import iommu_regbank_pkg::*;
#(
    parameter int ADDR_W  = RB_ADDR_W,
    parameter int DATA_W  = RB_DATA_W,
    parameter int CAUSE_W = RB_CAUSE_W
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               fault_valid,
    input logic [CAUSE_W-1:0] fault_cause,
    input logic               xlat_en,
    input logic [DATA_W-1:0]  table_base,
    input logic               oob_check_en,
    input logic               flush_pulse,
    input logic               irq,
    input logic [CAUSE_W-1:0] status_q,
    input logic [DATA_W-1:0]  faddr_q
);
    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (bus_addr == ADDR_W'(slot_offset(i))) mapped = 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> !xlat_en && !oob_check_en && !irq && !flush_pulse && table_base == '0);

    assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && bus_addr == ADDR_W'(slot_offset(SLOT_CTRL)) |=> xlat_en == $past(bus_wdata[EN_BIT]));

    assert_fault_sets_status_R6: assert property (@(posedge clk) disable iff (rst)
        fault_valid && fault_cause != '0 |=> (status_q & $past(fault_cause)) == $past(fault_cause));

    assert_first_fault_hold_R7: assert property (@(posedge clk) disable iff (rst)
        status_q != '0 && !(bus_sel && bus_wr && bus_addr == ADDR_W'(slot_offset(SLOT_STAT))) |=> $stable(faddr_q));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(fault_valid) || $past(bus_sel && bus_wr));

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |=> !flush_pulse);

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && !mapped |=> $stable(xlat_en) && $stable(table_base) && $stable(oob_check_en) && !flush_pulse);
endmodule

bind iommu_regbank iommu_rb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .fault_valid (fault_valid),
    .fault_cause (fault_cause),
    .xlat_en     (xlat_en),
    .table_base  (table_base),
    .oob_check_en(oob_check_en),
    .flush_pulse (flush_pulse),
    .irq         (irq),
    .status_q    (status_q),
    .faddr_q     (faddr_q)
);

// File: tb/sim_iommu_regbank.sv
`timescale 1ns/1ps
module sim_iommu_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fault_valid = 1'b0;
    logic [2:0]  fault_cause = '0;
    logic [31:0] fault_vaddr = '0;
    logic        xlat_en, oob_check_en, flush_pulse, irq;
    logic [31:0] table_base;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;

    always #2 clk = ~clk;

    iommu_regbank u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_vaddr(fault_vaddr),
        .xlat_en(xlat_en), .table_base(table_base), .oob_check_en(oob_check_en),
        .flush_pulse(flush_pulse), .irq(irq)
    );

    // behavioural reference model
    int unsigned m_base, m_faddr, m_rd;
    bit m_oob, m_xlat, m_exc, m_fl, m_pulse;
    int unsigned m_stat;

    always @(posedge clk) begin
        int unsigned rd, s;
        bit w, r;
        started = 1;
        if (rst) begin
            m_base = 0; m_faddr = 0; m_rd = 0; m_oob = 0; m_xlat = 0;
            m_exc = 0; m_fl = 0; m_pulse = 0; m_stat = 0;
        end else begin
            w = bus_sel && bus_wr;
            r = bus_sel && !bus_wr;
            rd = 0;
            if (r) begin
                case (bus_addr)
                    12'h38C: rd = m_base;
                    12'h1AC: rd = m_oob ? 32'h1000_0000 : 0;
                    12'h388: rd = m_xlat;
                    12'h380: rd = m_faddr;
                    12'h384: rd = m_stat;
                    12'h184: rd = m_fl ? 32'h10 : 0;
                    default: rd = 0;
                endcase
            end
            m_rd = rd;
            m_pulse = 0;
            s = m_stat;
            if (w) begin
                case (bus_addr)
                    12'h38C: m_base = bus_wdata;
                    12'h1AC: m_oob = bus_wdata[28];
                    12'h388: m_xlat = bus_wdata[0];
                    12'h380: m_exc = bus_wdata[0];
                    12'h384: s = s & bus_wdata[2:0];
                    12'h184: begin
                        if (bus_wdata[4] && !m_fl) m_pulse = 1;
                        m_fl = bus_wdata[4];
                    end
                    default: ;
                endcase
            end
            if (fault_valid && fault_cause != 0) begin
                if (s == 0) m_faddr = fault_vaddr;
                s = s | fault_cause;
            end
            m_stat = s;
        end
    end

    task automatic cmp(input string tag, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            cmp("R11 rdata", bus_rdata, m_rd);
            cmp("R2 table_base", table_base, m_base);
            cmp("R3 oob_check_en", oob_check_en, m_oob);
            cmp("R4 xlat_en", xlat_en, m_xlat);
            cmp("R9 flush_pulse", flush_pulse, m_pulse);
            cmp("R8 irq", irq, m_exc && m_stat != 0);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        cmp(tag, bus_rdata, exp);
    endtask

    task automatic fault(input logic [2:0] c, input logic [31:0] va);
        fault_valid = 1; fault_cause = c; fault_vaddr = va;
        @(negedge clk);
        fault_valid = 0; fault_cause = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state reads
        rd_chk(12'h38C, 0, "R1 base");
        rd_chk(12'h1AC, 0, "R1 cfg");
        rd_chk(12'h388, 0, "R1 ctrl");
        rd_chk(12'h380, 0, "R1 faddr");
        rd_chk(12'h384, 0, "R1 status");
        rd_chk(12'h184, 0, "R1 flush");
        cmp("R1 irq", irq, 0);
        // bring-up sequence
        wr(12'h38C, 32'hDEAD_B000);
        rd_chk(12'h38C, 32'hDEAD_B000, "R2 base readback");
        wr(12'h1AC, 32'hFFFF_FFFF);
        rd_chk(12'h1AC, 32'h1000_0000, "R3 cfg only bit 28");
        cmp("R3 oob out", oob_check_en, 1);
        wr(12'h380, 32'h1);
        wr(12'h388, 32'hFFFF_FFFF);
        rd_chk(12'h388, 32'h1, "R4 ctrl bit0");
        // flush: 1, 1, 0, 1
        wr(12'h184, 32'h10);
        cmp("R9 pulse after rising write", flush_pulse, 1);
        @(negedge clk);
        cmp("R9 pulse one cycle", flush_pulse, 0);
        wr(12'h184, 32'h10);
        cmp("R9 no pulse on repeat 1", flush_pulse, 0);
        rd_chk(12'h184, 32'h10, "R9 flush readback");
        wr(12'h184, 32'h0);
        wr(12'h184, 32'hFFFF_FFFF);
        cmp("R9 second pulse", flush_pulse, 1);
        // faults
        rd_chk(12'h380, 0, "R5 exc enable not read back");
        fault(3'b010, 32'h1234_5678);
        cmp("R8 irq after fault", irq, 1);
        fault(3'b100, 32'h9999_0000);
        rd_chk(12'h380, 32'h1234_5678, "R7 first fault kept");
        rd_chk(12'h384, 32'h6, "R6 status ORed");
        wr(12'h384, 32'h4);
        rd_chk(12'h384, 32'h4, "R6 partial keep");
        wr(12'h384, 32'h0);
        rd_chk(12'h384, 32'h0, "R6 clear");
        cmp("R8 irq low after clear", irq, 0);
        // clear and fault in the same cycle: fault wins
        wr(12'h384, 32'h0);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h384; bus_wdata = 0;
        fault_valid = 1; fault_cause = 3'b001; fault_vaddr = 32'hAAAA_0000;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; fault_valid = 0; fault_cause = 0;
        rd_chk(12'h384, 32'h1, "R6 fault after clear");
        rd_chk(12'h380, 32'hAAAA_0000, "R7 capture after clear");
        // zero cause ignored
        wr(12'h384, 32'h0);
        fault(3'b000, 32'h5555_5555);
        rd_chk(12'h384, 32'h0, "R7 zero cause no status");
        rd_chk(12'h380, 32'hAAAA_0000, "R7 zero cause no capture");
        // exception disable gates irq
        wr(12'h380, 32'h0);
        fault(3'b001, 32'h0000_1000);
        cmp("R8 irq gated", irq, 0);
        rd_chk(12'h384, 32'h1, "R8 status still set");
        wr(12'h380, 32'h1);
        cmp("R8 irq on enable", irq, 1);
        // unmapped offset
        wr(12'h200, 32'hFFFF_FFFF);
        rd_chk(12'h200, 0, "R10 unmapped read");
        rd_chk(12'h38C, 32'hDEAD_B000, "R10 base untouched");
        rd_chk(12'h388, 32'h1, "R10 ctrl untouched");
        // translation off
        wr(12'h388, 32'h0);
        cmp("R4 xlat off", xlat_en, 0);
        @(negedge clk);
        cmp("R11 idle rdata zero", bus_rdata, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule